// File: doc/BRIEF.md
# Serial-Input DAC Command Front End

This block is the digital front end of a 16-bit voltage-output DAC. A host writes 24-bit command words over a three-wire serial link: an active-low frame select, a serial clock and a data line. The block holds the DAC code and a two-bit output-state mode. It also produces the switch controls for a segmented converter core. The top four code bits become fifteen equally weighted segment enables in thermometer form. The lower twelve bits drive a binary ladder directly.

All three serial inputs are asynchronous to the block. Each one passes through a two-flop synchroniser clocked by a system clock that runs at least four times faster than the serial clock. Edges are detected in the system-clock domain. A frame is accepted only on its 24th falling serial-clock edge. At that edge the code and the mode are loaded together, and a one-cycle strobe marks the update. If frame select rises before that edge, the frame is discarded. A strap input picks the code that the block takes at reset.

Top module: `sdac_front`

## Requirements
- R1: While reset is held and after it is released, the code is 0x0000 when `mid_scale` is 0 and 0x8000 when it is 1; the mode is 2'b00 and `upd` is 0.
- R2: Words are sent MSB first. Word bits 23..18 are ignored, bits 17..16 form the mode and bits 15..0 form the code. Both registers load on the 24th falling serial-clock edge after frame select falls.
- R3: The mode output carries the received field unchanged: 00 normal, 01 output to ground through about 1 kOhm, 10 output to ground through about 100 kOhm, 11 output three-stated. All four values are accepted.
- R4: `upd` is high for exactly one system clock cycle per accepted word, in the cycle where the new code and mode first appear.
- R5: If frame select rises before the 24th falling edge, the code, the mode and `upd` do not change. The partial word is discarded, so the next frame assembles from empty.
- R6: After the 24th falling edge, further falling edges in the same frame are ignored until frame select goes high and falls again.
- R7: `seg_en[i]` is 1 exactly when the code's top four bits, read as an unsigned number, exceed i (i = 0..14).
- R8: `ladder` equals code bits 11..0.
- R9: The code and the mode change only in a cycle where `upd` is high.
- R10: Serial-clock falling edges while frame select is high shift nothing and load nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mid_scale | input | 1 | Reset strap: 1 selects midscale code, 0 zero scale |
| sel_n | input | 1 | Active-low frame select (asynchronous) |
| sck | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data, MSB first |
| code | output | 16 | Held DAC code |
| mode | output | 2 | Held output-state mode |
| upd | output | 1 | One-cycle strobe on an accepted word |
| seg_en | output | 15 | Thermometer enables from code bits 15..12 |
| ladder | output | 12 | Binary ladder bits, code bits 11..0 |

## Verification
The bench uses the default parameters: a 16-bit code with a four-bit segmented top, and a 24-bit word. The serial clock runs at one eighth of the system clock. Every one of the sixteen segment levels is swept against all four mode values, and each result is checked against an enable count and ladder value computed in the bench. With these small widths, aborted frames, extra edges after the 24th, clock edges outside a frame and both reset straps can all be run in a short test.

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int CODE_W      = 16,
  parameter int SEG_BITS    = 4,
  parameter int MODE_W      = 2,
  parameter int PAD_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 mid_scale,
  input  logic                                 sel_n,
  input  logic                                 sck,
  input  logic                                 sdi,
  output logic [CODE_W-1:0]                    code,
  output logic [MODE_W-1:0]                    mode,
  output logic                                 upd,
  output logic [(1<<SEG_BITS)-2:0]             seg_en,
  output logic [CODE_W-SEG_BITS-1:0]           ladder
);
  localparam int WORD_W   = PAD_W + MODE_W + CODE_W;
  localparam int LADDER_W = CODE_W - SEG_BITS;
  localparam int SEG_N    = (1 << SEG_BITS) - 1;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sel_sy, sck_sy, sdi_sy;
  logic                   sel_d, sck_d;
  logic                   armed;
  logic [CNT_W-1:0]       cnt;
  logic [WORD_W-2:0]      shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_sy <= '1;
      sck_sy <= '1;
      sdi_sy <= '0;
      sel_d  <= 1'b1;
      sck_d  <= 1'b1;
    end else begin
      sel_sy <= {sel_sy[SYNC_STAGES-2:0], sel_n};
      sck_sy <= {sck_sy[SYNC_STAGES-2:0], sck};
      sdi_sy <= {sdi_sy[SYNC_STAGES-2:0], sdi};
      sel_d  <= sel_sy[SYNC_STAGES-1];
      sck_d  <= sck_sy[SYNC_STAGES-1];
    end
  end

  wire sel_s    = sel_sy[SYNC_STAGES-1];
  wire sdi_s    = sdi_sy[SYNC_STAGES-1];
  wire sck_fall = sck_d & ~sck_sy[SYNC_STAGES-1];
  wire sel_fall = sel_d & ~sel_s;
  wire sel_rise = ~sel_d & sel_s;
  wire [WORD_W-1:0] word_nx = {shreg, sdi_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
      upd   <= 1'b0;
      mode  <= '0;
      code  <= mid_scale ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
    end else begin
      upd <= 1'b0;
      if (sel_s) begin
        armed <= 1'b0;
        cnt   <= '0;
        shreg <= '0;
      end else if (sel_fall) begin
        armed <= 1'b1;
        cnt   <= '0;
        shreg <= '0;
      end else if (armed && sck_fall) begin
        if (cnt == LAST) begin
          code  <= word_nx[CODE_W-1:0];
          mode  <= word_nx[CODE_W +: MODE_W];
          upd   <= 1'b1;
          armed <= 1'b0;
          cnt   <= '0;
          shreg <= '0;
        end else begin
          shreg <= word_nx[WORD_W-2:0];
          cnt   <= cnt + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < SEG_N; i++) begin : g_seg
    assign seg_en[i] = code[CODE_W-1 -: SEG_BITS] > SEG_BITS'(i);
  end
  assign ladder = code[LADDER_W-1:0];

  p_upd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);
  p_code_only_on_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code) |-> upd);
  p_mode_only_on_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> upd);
  p_full_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> ($past(cnt) == LAST));
  p_abort_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (cnt == '0) && !armed && !upd);
  p_thermo_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seg_en) == int'(code[CODE_W-1 -: SEG_BITS]));
endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mid_scale = 1'b0;
  logic sel_n = 1'b1;
  logic sck = 1'b1;
  logic sdi = 1'b0;
  logic [15:0] code;
  logic [1:0]  mode;
  logic        upd;
  logic [14:0] seg_en;
  logic [11:0] ladder;

  int checks = 0;
  int fails  = 0;
  int upd_cnt = 0;
  int upd_run = 0;
  int max_run = 0;

  always #4 clk = ~clk;

  sdac_front u_dut (
    .clk(clk), .rst_n(rst_n), .mid_scale(mid_scale),
    .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .code(code), .mode(mode), .upd(upd), .seg_en(seg_en), .ladder(ladder)
  );

  always @(negedge clk) begin
    if (upd) begin
      upd_cnt++;
      upd_run++;
      if (upd_run > max_run) max_run = upd_run;
    end else upd_run = 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clock_bits(logic [23:0] w, int n);
    for (int i = 0; i < n; i++) begin
      sdi = w[23-i];
      wait_n(4);
      sck = 1'b0;
      wait_n(4);
      sck = 1'b1;
    end
  endtask

  task automatic open_frame();
    sel_n = 1'b0;
    wait_n(6);
  endtask

  task automatic close_frame();
    wait_n(4);
    sel_n = 1'b1;
    wait_n(8);
  endtask

  task automatic send(logic [23:0] w);
    open_frame();
    clock_bits(w, 24);
    close_frame();
  endtask

  function automatic logic [14:0] thermo(logic [3:0] n);
    logic [14:0] t = '0;
    for (int i = 0; i < 15; i++) t[i] = (n > i);
    return t;
  endfunction

  task automatic check_state(string req, logic [15:0] c, logic [1:0] m);
    check({req, " code"}, 32'(code), 32'(c));
    check({req, " mode"}, 32'(mode), 32'(m));
    check("R7 seg_en", 32'(seg_en), 32'(thermo(c[15:12])));
    check("R8 ladder", 32'(ladder), 32'(c[11:0]));
  endtask

  task automatic do_reset(logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    mid_scale = strap;
    wait_n(4);
    check("R1 upd in reset", 32'(upd), 0);
    rst_n = 1'b1;
    wait_n(2);
    check_state("R1", strap ? 16'h8000 : 16'h0000, 2'b00);
    check("R1 upd", 32'(upd), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    logic [15:0] c;
    do_reset(1'b1);
    do_reset(1'b0);

    // R2 R3 R7 R8: every segment level against every mode
    for (int n = 0; n < 16; n++) begin
      for (int m = 0; m < 4; m++) begin
        c = {4'(n), 12'(n * 273 + m * 1021)};
        base = upd_cnt;
        send({6'b101101, 2'(m), c});
        check_state("R2 R3 load", c, 2'(m));
        check("R4 one strobe per word", 32'(upd_cnt - base), 1);
      end
    end
    check("R4 strobe width", 32'(max_run), 1);

    // R5: abort after 10 bits, then a clean frame
    send({8'h03, 16'h1234});
    base = upd_cnt;
    open_frame();
    clock_bits({8'hFF, 16'hFFFF}, 10);
    close_frame();
    check_state("R5 abort keeps", 16'h1234, 2'b11);
    check("R5 no strobe", 32'(upd_cnt - base), 0);
    open_frame();
    clock_bits({8'hFF, 16'hFFFF}, 23);
    close_frame();
    check_state("R5 abort at 23", 16'h1234, 2'b11);
    send({8'h01, 16'h0F0F});
    check_state("R5 next frame fresh", 16'h0F0F, 2'b01);

    // R6: extra edges after the 24th in one frame
    base = upd_cnt;
    open_frame();
    clock_bits({8'h02, 16'hA5C3}, 24);
    clock_bits({8'h03, 16'h5A3C}, 24);
    close_frame();
    check_state("R6 extra ignored", 16'hA5C3, 2'b10);
    check("R6 single strobe", 32'(upd_cnt - base), 1);

    // R10: clocking while frame select is high
    base = upd_cnt;
    clock_bits({8'h00, 16'hFFFF}, 24);
    wait_n(8);
    check_state("R10 idle clocking", 16'hA5C3, 2'b10);
    check("R10 no strobe", 32'(upd_cnt - base), 0);

    // R1 again after activity
    do_reset(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule